// File: doc/BRIEF.md
# Hall-Edge Retriggerable Tachometer Pulse Generator

This block turns rotor position feedback into a speed signal. It watches three Hall sensor lines and emits one fixed-width high pulse each time the commutation state changes, so the pulse rate follows motor speed while the duty cycle varies with it. A downstream filter or a counting timer turns the pulse train into a velocity value. A synchronous counter that counts down from a programmed cycle count sets the pulse width. This removes the need for an analog RC monostable.

The Hall lines are asynchronous. Each line passes through its own synchronizer, and the block then compares the line with its previous value. A rising or a falling transition on any line loads the on-time counter, and this also happens when a pulse is already running. The effective width is therefore measured from the most recent commutation. The on-time value is read only at a trigger, so software may rewrite it at any moment without changing a pulse in progress. An on-time of zero suppresses the output. No brake or coast input gates the counter, so pulses keep coming during braking. The on-time should be set below the shortest commutation interval expected at top speed. The reset input asserts asynchronously and is released through a local synchronizer.

Top module: `tach_oneshot`

## Requirements
- R1: While `rst_n` is low, `tach_o` is low.
- R2: A Hall pattern that is already present when reset is released produces no pulse. Only later changes trigger.
- R3: A 0-to-1 change on any one Hall line triggers a pulse. If the new value is first sampled at rising clock edge k, `tach_o` is still low after edge k+1 and is high after edge k+2.
- R4: A 1-to-0 change on any one Hall line triggers a pulse with the same latency as R3.
- R5: With no further Hall change, a triggered pulse keeps `tach_o` high for exactly `on_time_i` clock cycles.
- R6: A Hall change during a pulse reloads the full on-time. A change D cycles after the previous trigger gives one high run of D + `on_time_i` cycles.
- R7: A trigger taken while `on_time_i` is zero gives no pulse. If a pulse is running, that trigger ends it: `tach_o` is low after the edge where the trigger is taken.
- R8: `on_time_i` is captured only when a trigger is taken. A change during a pulse leaves that pulse's width alone and sets the width of the next pulse.
- R9: A change on several Hall lines in the same clock cycle gives one trigger, and so one pulse of `on_time_i` cycles.
- R10: Steady Hall inputs give no trigger. Changes spaced further apart than the on-time give exactly one pulse each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously inside |
| hall_i | input | 3 | Raw Hall lines, asynchronous to `clk`. Bit 0 is line A, bit 1 is line B, bit 2 is line C |
| on_time_i | input | 16 | Pulse width in clock cycles. Zero disables the output |
| tach_o | output | 1 | Registered tachometer pulse |

## Verification
The bench checks that a Hall pattern present at reset release does not fire a pulse. A design that arms the edge detector too early would show a spurious first pulse. It measures exact high-run lengths for a single edge, for a retrigger three cycles into a pulse, and for a zero on-time arriving mid-pulse. An off-by-one counter, a non-reloading counter or a missing cancel each gives a run of the wrong length. It rewrites the on-time during a pulse to catch a design that reads the value continuously instead of at the trigger. It also changes two lines at once to catch double triggering. A cycle-accurate reference model is compared on every clock, so any shift in the three-edge latency shows up at once.

// File: rtl/tach_pkg.sv
package tach_pkg;

  localparam int HALL_LINES_DEF  = 3;
  localparam int ON_W_DEF        = 16;
  localparam int SYNC_STAGES_DEF = 2;

  // Cycles after internal reset before edges are accepted: the synchronizer
  // must be filled and the previous-value register loaded once.
  function automatic int arm_cycles(input int stages);
    return stages + 2;
  endfunction

endpackage

// File: rtl/tach_rst_sync.sv
module tach_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/tach_hall_sync.sv
module tach_hall_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] hall_raw_i,
  output logic [LINES-1:0] hall_s_o
);

  for (genvar ln = 0; ln < LINES; ln++) begin : g_line
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    always_comb begin
      ff_d = {ff_q[STAGES-2:0], hall_raw_i[ln]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ff_q <= '0;
      end else begin
        ff_q <= ff_d;
      end
    end

    assign hall_s_o[ln] = ff_q[STAGES-1];
  end

endmodule

// File: rtl/tach_edge_det.sv
module tach_edge_det #(
  parameter int LINES    = 3,
  parameter int ARM_CYC  = 4,
  localparam int ARM_W   = $clog2(ARM_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] hall_s_i,
  output logic             trig_o
);

  logic [LINES-1:0] prev_q, prev_d;
  logic [ARM_W-1:0] arm_cnt_q, arm_cnt_d;
  logic             armed_q, armed_d;
  logic             arm_en;
  logic             any_change;

  always_comb begin
    prev_d     = hall_s_i;
    arm_en     = !armed_q;
    arm_cnt_d  = arm_cnt_q + 1'b1;
    armed_d    = (arm_cnt_q == ARM_W'(ARM_CYC - 1));
    any_change = |(hall_s_i ^ prev_q);
    trig_o     = armed_q & any_change;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt_q <= '0;
      armed_q   <= 1'b0;
    end else if (arm_en) begin
      arm_cnt_q <= arm_cnt_d;
      armed_q   <= armed_d;
    end
  end

  // R10
  steady_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hall_s_i) && $past(rst_n) |-> !trig_o);

  // R2
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

endmodule

// File: rtl/tach_pulse_timer.sv
module tach_pulse_timer #(
  parameter int ON_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic [ON_W-1:0] on_time_i,
  output logic            tach_o
);

  logic [ON_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            tach_q, tach_d;

  always_comb begin
    cnt_en = trig_i | (cnt_q != '0);
    if (trig_i) begin
      cnt_d = on_time_i;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    tach_d = cnt_en ? (cnt_d != '0) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tach_q <= 1'b0;
    end else begin
      tach_q <= tach_d;
    end
  end

  assign tach_o = tach_q;

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && (on_time_i != '0) |=> tach_o && (cnt_q == $past(on_time_i)));

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R7
  zero_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && (on_time_i == '0) |=> !tach_o);

  // R3
  rise_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tach_o) |-> $past(trig_i));

endmodule

// File: rtl/tach_oneshot.sv
module tach_oneshot #(
  parameter int HALL_LINES  = tach_pkg::HALL_LINES_DEF,
  parameter int ON_W        = tach_pkg::ON_W_DEF,
  parameter int SYNC_STAGES = tach_pkg::SYNC_STAGES_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HALL_LINES-1:0] hall_i,
  input  logic [ON_W-1:0]       on_time_i,
  output logic                  tach_o
);

  localparam int ARM_CYC = tach_pkg::arm_cycles(SYNC_STAGES);

  logic                  rst_n_int;
  logic [HALL_LINES-1:0] hall_s;
  logic                  trig;

  tach_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  tach_hall_sync #(.LINES(HALL_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .hall_raw_i (hall_i),
    .hall_s_o   (hall_s)
  );

  tach_edge_det #(.LINES(HALL_LINES), .ARM_CYC(ARM_CYC)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .hall_s_i (hall_s),
    .trig_o   (trig)
  );

  tach_pulse_timer #(.ON_W(ON_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .trig_i    (trig),
    .on_time_i (on_time_i),
    .tach_o    (tach_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |-> !tach_o);

endmodule

// File: tb/tb_tach_oneshot.sv
module tb_tach_oneshot;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [2:0]  hall_i;
  logic [15:0] on_time_i;
  logic        tach_o;

  int total_checks = 0;
  int bad_checks   = 0;
  string cur_req   = "R1";
  bit done = 0;

  tach_oneshot dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_i    (hall_i),
    .on_time_i (on_time_i),
    .tach_o    (tach_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int         m_cnt = 0;
  logic       m_tach = 1'b0;
  logic [2:0] d1, d2, d3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_tach = 1'b0;
      d1 = hall_i; d2 = hall_i; d3 = hall_i;
    end else begin
      if (d2 != d3) m_cnt = int'(on_time_i);
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_tach = (m_cnt > 0);
      d3 = d2; d2 = d1; d1 = hall_i;
    end
  end

  // high-run tracker
  int run_len  = 0;
  int last_run = 0;
  int runs_seen = 0;

  always @(negedge clk) begin
    #1;
    if (!done) begin
      total_checks++;
      if (tach_o !== m_tach) begin
        bad_checks++;
        $display("FAIL %s model compare at %0t: actual=%0b expected=%0b",
                 cur_req, $time, tach_o, m_tach);
      end
      if (tach_o === 1'b1) run_len++;
      else if (run_len > 0) begin
        last_run = run_len;
        run_len = 0;
        runs_seen++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total_checks++;
    if (act != exp) begin
      bad_checks++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_hall(input logic [2:0] v);
    @(negedge clk);
    #1 hall_i = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    int rs;
    rst_n = 1'b0;
    hall_i = 3'b101;
    on_time_i = 16'd5;

    cur_req = "R1";
    wait_cyc(3);
    chk("R1", int'(tach_o), 0);
    @(negedge clk); #1 rst_n = 1'b1;

    cur_req = "R2";
    wait_cyc(15);
    chk("R2", runs_seen, 0);
    chk("R2", int'(tach_o), 0);

    // R3: line B rises, latency and width
    cur_req = "R3";
    set_hall(3'b111);
    @(negedge clk); @(negedge clk); #2;
    chk("R3", int'(tach_o), 0);
    @(negedge clk); #2;
    chk("R3", int'(tach_o), 1);
    wait_cyc(10);
    chk("R5", last_run, 5);
    chk("R3", runs_seen, 1);

    // R4: line A falls
    cur_req = "R4";
    set_hall(3'b110);
    wait_cyc(12);
    chk("R4", runs_seen, 2);
    chk("R4", last_run, 5);

    // R6: retrigger 3 cycles later
    cur_req = "R6";
    on_time_i = 16'd8;
    set_hall(3'b010);
    wait_cyc(2);
    set_hall(3'b011);
    wait_cyc(20);
    chk("R6", last_run, 11);
    chk("R6", runs_seen, 3);

    // R7: zero on-time gives nothing, and cancels a running pulse
    cur_req = "R7";
    on_time_i = 16'd0;
    set_hall(3'b001);
    wait_cyc(10);
    chk("R7", runs_seen, 3);
    chk("R7", int'(tach_o), 0);
    on_time_i = 16'd10;
    set_hall(3'b101);
    wait_cyc(3);
    @(negedge clk); #1 on_time_i = 16'd0; hall_i = 3'b100;
    wait_cyc(15);
    chk("R7", last_run, 4);
    chk("R7", runs_seen, 4);

    // R8: on-time rewrite mid-pulse
    cur_req = "R8";
    on_time_i = 16'd6;
    set_hall(3'b110);
    wait_cyc(4);
    on_time_i = 16'd20;
    wait_cyc(10);
    chk("R8", last_run, 6);
    set_hall(3'b010);
    wait_cyc(26);
    chk("R8", last_run, 20);

    // R9: two lines change together
    cur_req = "R9";
    on_time_i = 16'd7;
    rs = runs_seen;
    set_hall(3'b001);
    wait_cyc(14);
    chk("R9", last_run, 7);
    chk("R9", runs_seen, rs + 1);

    // R10: steady rotation, one pulse per change
    cur_req = "R10";
    on_time_i = 16'd10;
    rs = runs_seen;
    for (int i = 0; i < 6; i++) begin
      case (i)
        0: set_hall(3'b101);
        1: set_hall(3'b100);
        2: set_hall(3'b110);
        3: set_hall(3'b010);
        4: set_hall(3'b011);
        default: set_hall(3'b001);
      endcase
      wait_cyc(25);
      chk("R10", last_run, 10);
    end
    chk("R10", runs_seen, rs + 6);
    wait_cyc(40);
    chk("R10", runs_seen, rs + 6);

    done = 1;
    summary();
    $finish;
  end

endmodule